// File: doc/BRIEF.md
# Branch Prediction History Queue

This block keeps one record for every branch the front end has predicted, and holds it until that branch either retires or is thrown away by a pipeline flush. Each hardware thread has its own ordered queue. A record holds the branch's sequence number, its PC, the direction that was predicted, an opaque history token from the direction predictor, and what the branch did to the return-address stack: either the stack slot index and value that were saved before a pop, or a flag that marks a push by a call.

Commands remove records from the queue and turn them into work for the neighbouring structures. A commit removes retired records from the oldest end and trains the direction predictor with what was predicted. A squash removes wrong-path records from the youngest end, and for each one it repairs the return-address stack. When the squash also reports a mispredict, the faulting branch's own record is then used to retrain the predictor with the real direction and to write the corrected target into the branch target buffer. After that, the record is dropped.

The queue removes one record per cycle and raises `busy` while a drain is running. The predictors and the stack themselves lie outside this block.

Top module: `brhist_queue`

## Requirements
- R1: After reset every queue is empty, `q_full` is all zero, `busy` is low and no command output is valid.
- R2: When the block is idle and neither a commit nor a squash is presented, an insert appends a record at the youngest end of thread `ins_tid`. Bit t of `q_full` is high exactly while thread t holds DEPTH (16) records. An insert to a full thread is ignored. An insert presented while `busy` is high, or in the same cycle as a commit or squash, is also ignored.
- R3: A commit with sequence number N for thread t removes records from the oldest end while their sequence number is at most N (unsigned compare). It removes one per cycle, oldest first. Each removal pulses `upd_valid` with the record's PC, its predicted direction and its history token.
- R4: A squash with sequence number N for thread t removes records from the youngest end while their sequence number is greater than N. It removes one per cycle, youngest first, and raises no predictor update for these records.
- R5: For each record removed in R4, a set used-stack flag gives a `stk_restore` pulse with the saved index and value. Otherwise a set was-call flag gives a `stk_pop` pulse. Otherwise no stack command is given.
- R6: On a squash with `sq_mispred` = 1, once the younger records are gone, a remaining youngest record whose sequence number equals N is removed. In that same cycle it pulses `upd_valid` with its PC, its history token and the direction `sq_taken`, and pulses `btb_valid` with its PC, `sq_target` and `sq_asid`. It gives no stack command. If no such record exists, nothing further is emitted.
- R7: Commands touch only the queue of the thread they name, and `cmd_tid` carries that thread on every command output.
- R8: `busy` is high from the cycle after a command is accepted until its drain ends. Commands presented while `busy` is high are ignored. A squash and a commit presented together while idle start the squash, and the commit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Insert a record |
| ins_tid | input | TW | Thread of the insert |
| ins_seq | input | 32 | Sequence number of the branch |
| ins_pc | input | 32 | PC of the branch |
| ins_taken | input | 1 | Predicted direction |
| ins_hist | input | 8 | Predictor history token |
| ins_used_stk | input | 1 | Branch popped the return stack |
| ins_stk_idx | input | 4 | Saved stack index |
| ins_stk_val | input | 32 | Saved stack value |
| ins_was_call | input | 1 | Branch pushed the return stack |
| cmt_valid | input | 1 | Commit command |
| cmt_tid | input | TW | Thread of the commit |
| cmt_seq | input | 32 | Highest retired sequence number |
| sq_valid | input | 1 | Squash command |
| sq_tid | input | TW | Thread of the squash |
| sq_seq | input | 32 | Last surviving sequence number |
| sq_mispred | input | 1 | Squash carries a mispredict correction |
| sq_taken | input | 1 | Actual direction of the faulting branch |
| sq_target | input | 32 | Corrected target |
| sq_asid | input | 8 | Address-space identifier for the target buffer |
| q_full | output | NTHREADS | Per-thread full flags |
| busy | output | 1 | Drain in progress |
| upd_valid | output | 1 | Direction predictor update |
| upd_pc | output | 32 | Update PC |
| upd_taken | output | 1 | Update direction |
| upd_hist | output | 8 | Update history token |
| btb_valid | output | 1 | Target buffer update |
| btb_pc | output | 32 | Target buffer PC |
| btb_target | output | 32 | Target buffer target |
| btb_asid | output | 8 | Target buffer address space |
| stk_restore | output | 1 | Return stack restore |
| stk_pop | output | 1 | Return stack pop |
| stk_idx | output | 4 | Restore index |
| stk_val | output | 32 | Restore value |
| cmd_tid | output | TW | Thread of the current command outputs |

## Verification
The assertions take for granted that the upstream logic holds off commands while `busy` is high. They also assume that a thread's sequence numbers rise in insert order, so that both drains stop at the first record that fails the comparison. The stimulus gives every thread strictly increasing sequence numbers, never retires past a record it intends to squash, and only once presents a command during a drain, on purpose, to check that it is ignored.

// File: rtl/brhist_pkg.sv
// Shared widths and types for the branch prediction history queue.
// Assumes a single PC width for branch PCs and return-stack values.
package brhist_pkg;
    localparam int SEQ_W  = 32;
    localparam int PC_W   = 32;
    localparam int HIST_W = 8;
    localparam int SIDX_W = 4;
    localparam int ASID_W = 8;

    typedef struct packed {
        logic [SEQ_W-1:0]  seq;
        logic [PC_W-1:0]   pc;
        logic              taken;
        logic [HIST_W-1:0] hist;
        logic              used_stk;
        logic [SIDX_W-1:0] stk_idx;
        logic [PC_W-1:0]   stk_val;
        logic              was_call;
    } br_rec_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_SQUASH = 2'd2
    } drain_st_e;
endpackage

// File: rtl/brhist_ring.sv
// One thread's record queue: a circular buffer with a push at the young
// end and removal at either end. Assumes DEPTH is a power of two and that
// the controller never pushes when full, never pops when empty and never
// does more than one operation per cycle.
module brhist_ring
    import brhist_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    push,
    input  br_rec_t push_rec,
    input  logic    pop_old,
    input  logic    pop_young,
    output br_rec_t old_rec,
    output br_rec_t young_rec,
    output logic    empty,
    output logic    full
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = IW + 1;

    br_rec_t        mem [DEPTH];
    logic [IW-1:0]  head_q;
    logic [CW-1:0]  cnt_q;
    logic [IW-1:0]  tail_idx;
    logic [IW-1:0]  young_idx;

    assign tail_idx  = head_q + cnt_q[IW-1:0];
    assign young_idx = head_q + cnt_q[IW-1:0] - IW'(1);
    assign empty     = (cnt_q == '0);
    assign full      = (cnt_q == CW'(DEPTH));
    assign old_rec   = mem[head_q];
    assign young_rec = mem[young_idx];

    // Write the new record into the slot after the youngest one.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[tail_idx] <= push_rec;
        end
    end

    // Track the oldest slot and the record count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            cnt_q  <= '0;
        end else if (push) begin
            cnt_q <= cnt_q + CW'(1);
        end else if (pop_old) begin
            head_q <= head_q + IW'(1);
            cnt_q  <= cnt_q - CW'(1);
        end else if (pop_young) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assert_no_push_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_full_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop_old && !pop_young) |=> full);
    assert_no_pop_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_old || pop_young) |-> !empty);
    assert_one_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push, pop_old, pop_young}));
endmodule

// File: rtl/brhist_ctrl.sv
// Drain controller: accepts inserts and commands while idle, then removes
// one record per cycle from the selected thread's queue, and registers the
// resulting predictor, target-buffer and stack commands. Assumes sequence
// numbers rise in insert order within a thread.
module brhist_ctrl
    import brhist_pkg::*;
#(
    parameter int NTHREADS = 2,
    parameter int TW       = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic              ins_full,
    input  logic              cmt_valid,
    input  logic [TW-1:0]     cmt_tid,
    input  logic [SEQ_W-1:0]  cmt_seq,
    input  logic              sq_valid,
    input  logic [TW-1:0]     sq_tid,
    input  logic [SEQ_W-1:0]  sq_seq,
    input  logic              sq_mispred,
    input  logic              sq_taken,
    input  logic [PC_W-1:0]   sq_target,
    input  logic [ASID_W-1:0] sq_asid,
    input  br_rec_t           sel_old,
    input  br_rec_t           sel_young,
    input  logic              sel_empty,
    output logic              ins_accept,
    output logic              pop_old,
    output logic              pop_young,
    output logic [TW-1:0]     act_tid,
    output logic              busy,
    output logic              upd_valid,
    output logic [PC_W-1:0]   upd_pc,
    output logic              upd_taken,
    output logic [HIST_W-1:0] upd_hist,
    output logic              btb_valid,
    output logic [PC_W-1:0]   btb_pc,
    output logic [PC_W-1:0]   btb_target,
    output logic [ASID_W-1:0] btb_asid,
    output logic              stk_restore,
    output logic              stk_pop,
    output logic [SIDX_W-1:0] stk_idx,
    output logic [PC_W-1:0]   stk_val,
    output logic [TW-1:0]     cmd_tid
);
    drain_st_e          st_q;
    logic [SEQ_W-1:0]   lim_q;
    logic               mis_q;
    logic               act_dir_q;
    logic [PC_W-1:0]    tgt_q;
    logic [ASID_W-1:0]  asid_q;
    logic               idle;
    logic               start_sq;
    logic               start_cm;
    logic               cm_take;
    logic               sq_take;
    logic               fix_take;
    br_rec_t            rec;

    assign idle       = (st_q == ST_IDLE);
    assign busy       = !idle;
    assign start_sq   = idle && sq_valid;
    assign start_cm   = idle && cmt_valid && !sq_valid;
    assign ins_accept = idle && ins_valid && !sq_valid && !cmt_valid && !ins_full;

    // Decide whether the record at the active end leaves this cycle.
    always_comb begin
        cm_take  = (st_q == ST_COMMIT) && !sel_empty && (sel_old.seq <= lim_q);
        sq_take  = (st_q == ST_SQUASH) && !sel_empty && (sel_young.seq > lim_q);
        fix_take = (st_q == ST_SQUASH) && !sel_empty && mis_q
                   && (sel_young.seq == lim_q);
        rec      = cm_take ? sel_old : sel_young;
    end

    assign pop_old   = cm_take;
    assign pop_young = sq_take || fix_take;

    // Latch an accepted command and step the drain state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            act_tid   <= '0;
            lim_q     <= '0;
            mis_q     <= 1'b0;
            act_dir_q <= 1'b0;
            tgt_q     <= '0;
            asid_q    <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_sq) begin
                        st_q      <= ST_SQUASH;
                        act_tid   <= sq_tid;
                        lim_q     <= sq_seq;
                        mis_q     <= sq_mispred;
                        act_dir_q <= sq_taken;
                        tgt_q     <= sq_target;
                        asid_q    <= sq_asid;
                    end else if (start_cm) begin
                        st_q    <= ST_COMMIT;
                        act_tid <= cmt_tid;
                        lim_q   <= cmt_seq;
                    end
                end
                ST_COMMIT: begin
                    if (!cm_take) st_q <= ST_IDLE;
                end
                ST_SQUASH: begin
                    if (fix_take || !sq_take) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Register the command pulses produced by this cycle's removal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_valid   <= 1'b0;
            upd_pc      <= '0;
            upd_taken   <= 1'b0;
            upd_hist    <= '0;
            btb_valid   <= 1'b0;
            btb_pc      <= '0;
            btb_target  <= '0;
            btb_asid    <= '0;
            stk_restore <= 1'b0;
            stk_pop     <= 1'b0;
            stk_idx     <= '0;
            stk_val     <= '0;
            cmd_tid     <= '0;
        end else begin
            upd_valid   <= cm_take || fix_take;
            upd_pc      <= rec.pc;
            upd_taken   <= fix_take ? act_dir_q : rec.taken;
            upd_hist    <= rec.hist;
            btb_valid   <= fix_take;
            btb_pc      <= rec.pc;
            btb_target  <= tgt_q;
            btb_asid    <= asid_q;
            stk_restore <= sq_take && rec.used_stk;
            stk_pop     <= sq_take && !rec.used_stk && rec.was_call;
            stk_idx     <= rec.stk_idx;
            stk_val     <= rec.stk_val;
            cmd_tid     <= act_tid;
        end
    end

    assert_quiet_after_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |=> !(upd_valid || btb_valid || stk_restore || stk_pop));
    assert_fix_ends_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        btb_valid |-> (upd_valid && !busy));
    assert_stack_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_restore || stk_pop) |-> !upd_valid);
endmodule

// File: rtl/brhist_queue.sv
// Top of the branch prediction history queue: one ring per hardware thread,
// a shared drain controller and the per-thread selection between them.
// Assumes commands are only presented while busy is low.
module brhist_queue
    import brhist_pkg::*;
#(
    parameter int NTHREADS = 2,
    parameter int DEPTH    = 16,
    parameter int TW       = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ins_valid,
    input  logic [TW-1:0]       ins_tid,
    input  logic [SEQ_W-1:0]    ins_seq,
    input  logic [PC_W-1:0]     ins_pc,
    input  logic                ins_taken,
    input  logic [HIST_W-1:0]   ins_hist,
    input  logic                ins_used_stk,
    input  logic [SIDX_W-1:0]   ins_stk_idx,
    input  logic [PC_W-1:0]     ins_stk_val,
    input  logic                ins_was_call,
    input  logic                cmt_valid,
    input  logic [TW-1:0]       cmt_tid,
    input  logic [SEQ_W-1:0]    cmt_seq,
    input  logic                sq_valid,
    input  logic [TW-1:0]       sq_tid,
    input  logic [SEQ_W-1:0]    sq_seq,
    input  logic                sq_mispred,
    input  logic                sq_taken,
    input  logic [PC_W-1:0]     sq_target,
    input  logic [ASID_W-1:0]   sq_asid,
    output logic [NTHREADS-1:0] q_full,
    output logic                busy,
    output logic                upd_valid,
    output logic [PC_W-1:0]     upd_pc,
    output logic                upd_taken,
    output logic [HIST_W-1:0]   upd_hist,
    output logic                btb_valid,
    output logic [PC_W-1:0]     btb_pc,
    output logic [PC_W-1:0]     btb_target,
    output logic [ASID_W-1:0]   btb_asid,
    output logic                stk_restore,
    output logic                stk_pop,
    output logic [SIDX_W-1:0]   stk_idx,
    output logic [PC_W-1:0]     stk_val,
    output logic [TW-1:0]       cmd_tid
);
    br_rec_t               new_rec;
    br_rec_t               old_a   [NTHREADS];
    br_rec_t               young_a [NTHREADS];
    logic [NTHREADS-1:0]   empty_v;
    logic                  ins_accept;
    logic                  pop_old;
    logic                  pop_young;
    logic [TW-1:0]         act_tid;

    // Pack the insert port into one record.
    always_comb begin
        new_rec.seq      = ins_seq;
        new_rec.pc       = ins_pc;
        new_rec.taken    = ins_taken;
        new_rec.hist     = ins_hist;
        new_rec.used_stk = ins_used_stk;
        new_rec.stk_idx  = ins_stk_idx;
        new_rec.stk_val  = ins_stk_val;
        new_rec.was_call = ins_was_call;
    end

    for (genvar t = 0; t < NTHREADS; t++) begin : g_thr
        brhist_ring #(.DEPTH(DEPTH)) u_ring (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (ins_accept && (ins_tid == TW'(t))),
            .push_rec  (new_rec),
            .pop_old   (pop_old && (act_tid == TW'(t))),
            .pop_young (pop_young && (act_tid == TW'(t))),
            .old_rec   (old_a[t]),
            .young_rec (young_a[t]),
            .empty     (empty_v[t]),
            .full      (q_full[t])
        );
    end

    brhist_ctrl #(.NTHREADS(NTHREADS), .TW(TW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ins_valid   (ins_valid),
        .ins_full    (q_full[ins_tid]),
        .cmt_valid   (cmt_valid),
        .cmt_tid     (cmt_tid),
        .cmt_seq     (cmt_seq),
        .sq_valid    (sq_valid),
        .sq_tid      (sq_tid),
        .sq_seq      (sq_seq),
        .sq_mispred  (sq_mispred),
        .sq_taken    (sq_taken),
        .sq_target   (sq_target),
        .sq_asid     (sq_asid),
        .sel_old     (old_a[act_tid]),
        .sel_young   (young_a[act_tid]),
        .sel_empty   (empty_v[act_tid]),
        .ins_accept  (ins_accept),
        .pop_old     (pop_old),
        .pop_young   (pop_young),
        .act_tid     (act_tid),
        .busy        (busy),
        .upd_valid   (upd_valid),
        .upd_pc      (upd_pc),
        .upd_taken   (upd_taken),
        .upd_hist    (upd_hist),
        .btb_valid   (btb_valid),
        .btb_pc      (btb_pc),
        .btb_target  (btb_target),
        .btb_asid    (btb_asid),
        .stk_restore (stk_restore),
        .stk_pop     (stk_pop),
        .stk_idx     (stk_idx),
        .stk_val     (stk_val),
        .cmd_tid     (cmd_tid)
    );

    assert_insert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ins_accept |=> !busy);
endmodule

// File: tb/brhist_queue_bench.sv
// Directed bench for the branch prediction history queue.
module brhist_queue_bench;
    import brhist_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              ins_valid = 0, ins_taken = 0, ins_used_stk = 0, ins_was_call = 0;
    logic [0:0]        ins_tid = 0, cmt_tid = 0, sq_tid = 0, cmd_tid;
    logic [31:0]       ins_seq = 0, ins_pc = 0, ins_stk_val = 0, cmt_seq = 0, sq_seq = 0, sq_target = 0;
    logic [7:0]        ins_hist = 0, sq_asid = 0;
    logic [3:0]        ins_stk_idx = 0;
    logic              cmt_valid = 0, sq_valid = 0, sq_mispred = 0, sq_taken = 0;
    logic [1:0]        q_full;
    logic              busy, upd_valid, upd_taken, btb_valid, stk_restore, stk_pop;
    logic [31:0]       upd_pc, btb_pc, btb_target, stk_val;
    logic [7:0]        upd_hist, btb_asid;
    logic [3:0]        stk_idx;

    brhist_queue u_brhist_queue (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_tid(ins_tid), .ins_seq(ins_seq), .ins_pc(ins_pc),
        .ins_taken(ins_taken), .ins_hist(ins_hist), .ins_used_stk(ins_used_stk),
        .ins_stk_idx(ins_stk_idx), .ins_stk_val(ins_stk_val), .ins_was_call(ins_was_call),
        .cmt_valid(cmt_valid), .cmt_tid(cmt_tid), .cmt_seq(cmt_seq),
        .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq), .sq_mispred(sq_mispred),
        .sq_taken(sq_taken), .sq_target(sq_target), .sq_asid(sq_asid),
        .q_full(q_full), .busy(busy),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_hist(upd_hist),
        .btb_valid(btb_valid), .btb_pc(btb_pc), .btb_target(btb_target), .btb_asid(btb_asid),
        .stk_restore(stk_restore), .stk_pop(stk_pop), .stk_idx(stk_idx), .stk_val(stk_val),
        .cmd_tid(cmd_tid)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Event logs filled by the monitor.
    int          n_u, n_s, n_b;
    logic [31:0] u_pc [64];
    logic        u_tk [64];
    logic [7:0]  u_hist [64];
    logic [0:0]  u_tid [64];
    int          s_kind [64];
    logic [3:0]  s_idx [64];
    logic [31:0] s_val [64];
    logic [31:0] b_pc, b_tgt;
    logic [7:0]  b_asid;

    function automatic logic [31:0] pcf(input logic [31:0] s); return 32'h1000 + s * 4; endfunction
    function automatic logic [7:0]  hf(input logic [31:0] s);  return s[7:0] ^ 8'h5A; endfunction
    function automatic logic [31:0] svf(input logic [31:0] s); return 32'h8000_0000 | s; endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (upd_valid && n_u < 64) begin
            u_pc[n_u] = upd_pc; u_tk[n_u] = upd_taken; u_hist[n_u] = upd_hist; u_tid[n_u] = cmd_tid;
            n_u++;
        end
        if ((stk_restore || stk_pop) && n_s < 64) begin
            s_kind[n_s] = stk_restore ? 1 : 2; s_idx[n_s] = stk_idx; s_val[n_s] = stk_val;
            n_s++;
        end
        if (btb_valid) begin
            b_pc = btb_pc; b_tgt = btb_target; b_asid = btb_asid; n_b++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic clear_ev(); n_u = 0; n_s = 0; n_b = 0; endtask

    task automatic ins(input int tid, input int seq, input bit used, input int idx, input bit call);
        @(negedge clk);
        ins_valid = 1; ins_tid = 1'(tid); ins_seq = seq; ins_pc = pcf(seq);
        ins_taken = ins_seq[0]; ins_hist = hf(seq); ins_used_stk = used;
        ins_stk_idx = 4'(idx); ins_stk_val = svf(seq); ins_was_call = call;
        @(negedge clk);
        ins_valid = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic commit(input int tid, input int n);
        @(negedge clk);
        clear_ev();
        cmt_valid = 1; cmt_tid = 1'(tid); cmt_seq = n;
        @(negedge clk);
        cmt_valid = 0;
        wait_idle();
    endtask

    task automatic squash(input int tid, input int n, input bit mis, input bit act,
                          input logic [31:0] tgt, input logic [7:0] asid);
        @(negedge clk);
        clear_ev();
        sq_valid = 1; sq_tid = 1'(tid); sq_seq = n; sq_mispred = mis;
        sq_taken = act; sq_target = tgt; sq_asid = asid;
        @(negedge clk);
        sq_valid = 0;
        wait_idle();
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 full", q_full, 0);
        chk("R1 no outputs", {upd_valid, btb_valid, stk_restore, stk_pop}, 0);
    endtask

    task automatic t_commit();
        ins(0, 10, 0, 0, 0); ins(0, 20, 0, 0, 0); ins(0, 30, 0, 0, 0); ins(0, 40, 0, 0, 0);
        commit(0, 25);
        chk("R3 count", n_u, 2);
        chk("R3 first pc", u_pc[0], pcf(10));
        chk("R3 second pc", u_pc[1], pcf(20));
        chk("R3 dir/hist", {u_tk[1], u_hist[1]}, {1'b0, hf(20)});
        commit(0, 5);
        chk("R3 none below", n_u, 0);
        commit(0, 30);
        chk("R3 equal count", n_u, 1);
        chk("R3 equal pc", u_pc[0], pcf(30));
    endtask

    task automatic t_squash();
        ins(0, 50, 1, 3, 0); ins(0, 60, 0, 0, 1); ins(0, 70, 0, 0, 0);
        squash(0, 45, 0, 0, 0, 0);
        chk("R4 no update", n_u, 0);
        chk("R5 stack count", n_s, 2);
        chk("R5 pop first", s_kind[0], 2);
        chk("R5 restore second", {s_kind[1][3:0], s_idx[1], s_val[1]}, {4'd1, 4'd3, svf(50)});
    endtask

    task automatic t_mispred();
        ins(0, 80, 0, 0, 1); ins(0, 90, 1, 7, 0);
        squash(0, 80, 1, 1, 32'hCAFE_0000, 8'h2C);
        chk("R5 restore of younger", {n_s[3:0], s_idx[0], s_val[0]}, {4'd1, 4'd7, svf(90)});
        chk("R6 update count", n_u, 1);
        chk("R6 update fields", {u_pc[0], u_tk[0], u_hist[0]}, {pcf(80), 1'b1, hf(80)});
        chk("R6 btb count", n_b, 1);
        chk("R6 btb fields", {b_pc, b_tgt, b_asid}, {pcf(80), 32'hCAFE_0000, 8'h2C});
        commit(0, 1000);
        chk("R6 fault removed", n_u, 1);
        chk("R6 survivor", u_pc[0], pcf(40));
        ins(0, 60, 0, 0, 0);
        squash(0, 55, 1, 1, 32'h1234, 8'h01);
        chk("R6 absent fault", {n_u[3:0], n_b[3:0], n_s[3:0]}, 0);
        commit(0, 1000);
        chk("R4 queue emptied", n_u, 0);
    endtask

    task automatic t_full();
        for (int s = 1; s <= 16; s++) ins(1, s, 0, 0, 0);
        chk("R2 full flag", q_full, 2'b10);
        ins(1, 17, 0, 0, 0);
        commit(1, 1000);
        chk("R2 refused when full", n_u, 16);
        chk("R2 last kept", u_pc[15], pcf(16));
        chk("R7 tid on updates", u_tid[0], 1);
        chk("R2 full cleared", q_full, 0);
    endtask

    task automatic t_threads();
        ins(0, 5, 0, 0, 0); ins(1, 6, 0, 0, 0);
        commit(1, 1000);
        chk("R7 thread1 only", n_u, 1);
        chk("R7 thread1 record", {u_pc[0], u_tid[0]}, {pcf(6), 1'b1});
        commit(0, 1000);
        chk("R7 thread0 record", {n_u[3:0], u_pc[0], u_tid[0]}, {4'd1, pcf(5), 1'b0});
    endtask

    task automatic t_priority();
        ins(0, 7, 1, 1, 0);
        @(negedge clk);
        clear_ev();
        cmt_valid = 1; cmt_tid = 0; cmt_seq = 1000;
        sq_valid = 1; sq_tid = 0; sq_seq = 1000; sq_mispred = 0;
        @(negedge clk);
        cmt_valid = 0; sq_valid = 0;
        chk("R8 busy after accept", busy, 1);
        wait_idle();
        chk("R8 commit dropped", n_u, 0);
        ins(0, 8, 1, 2, 0); ins(0, 9, 1, 3, 0);
        @(negedge clk);
        clear_ev();
        cmt_valid = 1; cmt_tid = 0; cmt_seq = 1000;
        @(negedge clk);
        cmt_valid = 0;
        sq_valid = 1; sq_tid = 0; sq_seq = 0; sq_mispred = 0;
        @(negedge clk);
        sq_valid = 0;
        wait_idle();
        chk("R8 commit completes", n_u, 3);
        chk("R8 squash while busy ignored", n_s, 0);
    endtask

    initial begin
        clear_ev();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_commit();
        t_squash();
        t_mispred();
        t_full();
        t_threads();
        t_priority();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule